// File: doc/BRIEF.md
# Serial Management Register Slave

This block sits on the register side of a two-wire serial management link and answers the frames a host sends to it. The host drives a clock bit, a data bit and an output-enable bit from software, so the link clock is only a level that the block samples on its own system clock. A rising edge found in that level marks one serial bit time. On each such edge the block shifts in one data bit, provided the host is also enabling its driver.

A frame starts once 32 consecutive ones have been seen. Next come a 2-bit start code, a 2-bit opcode, a 5-bit device address, a 5-bit register address and a 2-bit turnaround. On a valid read, the 16-bit content of the selected register in a 32-entry bank is returned, most significant bit first, on the returned-data bit over the next 16 edges. On a valid write, the 16 data bits are taken in and thrown away. The bank is fixed at its reset contents: zero everywhere, except two identifier entries.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: After reset the returned-data bit is 0. Register 2 reads 0x0022, register 3 reads 0x161A and every other register reads 0x0000.
- R2: A bit is taken only on a system clock cycle where the link clock bit is 1 and was 0 in the previous cycle. Holding the link clock high over many cycles counts as one bit.
- R3: The bit taken is 1 only when both the host data bit and the host enable bit are 1. Otherwise it is 0, so a preamble sent with the enable low never synchronises.
- R4: Bits enter a 32-bit history from its low end. Whenever that history becomes all ones, the slave resynchronises. Thirty-one ones after zeros give no sync, and a preamble longer than 32 ones still works.
- R5: The 16 bits after sync are sent first-to-last as follows: start, which must be 01; opcode, where 10 is read and 01 is write; 5 device-address bits, which are not compared; 5 register-address bits, most significant first; and 2 turnaround bits.
- R6: A read is accepted when the second turnaround bit taken is 0, whatever the first one is. Each of the next 16 edges then puts the next register bit on the returned-data bit, from bit 15 down to bit 0.
- R7: A frame whose start code, opcode or turnaround is invalid gets no answer. The returned-data bit keeps its previous value.
- R8: A write is accepted only with turnaround 10. Its 16 data bits are taken on the following edges and discarded, so later reads still return the reset contents.
- R9: The returned-data bit changes only in the cycle of a detected link-clock rising edge. Changes to the host data or enable bits between edges leave it unchanged.
- R10: Thirty-two edges after sync, the frame ends. Any further frame sent without a new preamble gets no answer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mdc_bit | input | 1 | Software-driven link clock level |
| mdo_bit | input | 1 | Host data bit |
| mdo_en | input | 1 | Host driver enable |
| mdi_bit | output | 1 | Returned data bit, registered |

## Verification
The hardest state to reach from the ports is the middle of a read answer. There the returned-data bit is 1 while the host changes its data and enable bits and lowers the link clock without a new rising edge. The stimulus gets there by stopping a register-2 read after eleven answer edges, when bit 5 (a 1) is on the line. It then wiggles the host bits for several cycles, checks that the bit held, and then finishes the last five edges. Short preambles, preambles sent with the enable low, and frames sent after the end of a frame without a new preamble are also sent. They make sure a stale sync cannot produce a spurious answer.

// File: rtl/mdio_slave_pkg.sv
package mdio_slave_pkg;
  typedef enum logic [1:0] {
    MS_IDLE  = 2'd0,
    MS_READ  = 2'd1,
    MS_WRITE = 2'd2
  } mslv_state_t;

  localparam logic [1:0] START_CODE = 2'b01;
  localparam logic [1:0] OPC_WRITE  = 2'b01;
  localparam logic [1:0] OPC_READ   = 2'b10;
  localparam logic [1:0] TURN_WRITE = 2'b10;
endpackage

// File: rtl/mdio_edge_detect.sv
module mdio_edge_detect (
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  output logic rise_o
);
  logic level_q;

  always_ff @(posedge clk) begin
    if (rst) level_q <= 1'b0;
    else     level_q <= level_i;
  end

  assign rise_o = level_i & ~level_q;
endmodule

// File: rtl/mdio_regbank.sv
module mdio_regbank #(
  parameter int          ADDR_W  = 5,
  parameter int          DATA_W  = 16,
  parameter int          ID0_IDX = 2,
  parameter logic [15:0] ID0_VAL = 16'h0022,
  parameter int          ID1_IDX = 3,
  parameter logic [15:0] ID1_VAL = 16'h161A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] bank_q [DEPTH];

  // The bank only loads on reset; host writes never reach it.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (i == ID0_IDX)      bank_q[i] <= DATA_W'(ID0_VAL);
        else if (i == ID1_IDX) bank_q[i] <= DATA_W'(ID1_VAL);
        else                   bank_q[i] <= '0;
      end
    end
  end

  assign rd_data_o = bank_q[rd_addr_i];
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_slave_pkg::*;
#(
  parameter int PRE_W  = 32,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5,
  localparam int CNT_W = $clog2(PRE_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rise_i,
  input  logic              bit_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              din_o,
  output mslv_state_t       state_o,
  output logic              active_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam int HDR_W = DATA_W;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PRE_W);
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(PRE_W - HDR_W);

  logic [PRE_W-1:0]  hist_q, hist_n;
  logic [CNT_W-1:0]  cnt_q, cnt_eff;
  logic              active_q, active_eff, sync_hit;
  logic              at_decode, at_end, shift_out;
  mslv_state_t       state_q, state_n;
  logic [DATA_W-1:0] out_q;
  logic              din_q;
  logic [1:0]        f_start, f_op, f_turn;

  always_comb begin
    hist_n     = {hist_q[PRE_W-2:0], bit_i};
    sync_hit   = &hist_n;
    active_eff = sync_hit | active_q;
    cnt_eff    = sync_hit ? CNT_LOAD : cnt_q;
    at_decode  = active_eff && (cnt_eff == CNT_HDR);
    at_end     = active_eff && (cnt_eff == '0);

    f_start    = hist_n[HDR_W-1 -: 2];
    f_op       = hist_n[HDR_W-3 -: 2];
    f_turn     = hist_n[1:0];
    rd_addr_o  = hist_n[2 +: ADDR_W];

    state_n = state_q;
    if (at_decode) begin
      if (f_start == START_CODE && f_op == OPC_WRITE && f_turn == TURN_WRITE)
        state_n = MS_WRITE;
      else if (f_start == START_CODE && f_op == OPC_READ && !f_turn[0])
        state_n = MS_READ;
      else
        state_n = MS_IDLE;
    end

    shift_out = active_eff && (cnt_eff < CNT_HDR) && (state_n == MS_READ);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q   <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
      state_q  <= MS_IDLE;
      out_q    <= '0;
      din_q    <= 1'b0;
    end else if (rise_i) begin
      hist_q <= hist_n;
      // At the last edge a write's data sits in hist_n[DATA_W-1:0]; it is dropped.
      state_q <= at_end ? MS_IDLE : state_n;
      if (at_decode && state_n == MS_READ) begin
        out_q <= rd_data_i;
      end else if (shift_out) begin
        din_q <= out_q[DATA_W-1];
        out_q <= {out_q[DATA_W-2:0], 1'b0};
      end
      if (active_eff) begin
        if (at_end) begin
          active_q <= 1'b0;
          cnt_q    <= '0;
        end else begin
          active_q <= 1'b1;
          cnt_q    <= cnt_eff - 1'b1;
        end
      end
    end
  end

  assign din_o    = din_q;
  assign state_o  = state_q;
  assign active_o = active_q;
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave
  import mdio_slave_pkg::*;
#(
  parameter int          PRE_W   = 32,
  parameter int          DATA_W  = 16,
  parameter int          ADDR_W  = 5,
  parameter int          ID0_IDX = 2,
  parameter logic [15:0] ID0_VAL = 16'h0022,
  parameter int          ID1_IDX = 3,
  parameter logic [15:0] ID1_VAL = 16'h161A
) (
  input  logic clk,
  input  logic rst,
  input  logic mdc_bit,
  input  logic mdo_bit,
  input  logic mdo_en,
  output logic mdi_bit
);
  localparam int CNT_W = $clog2(PRE_W + 1);

  logic              edge_rise;
  logic              line_bit;
  logic [ADDR_W-1:0] bank_addr;
  logic [DATA_W-1:0] bank_data;
  mslv_state_t       eng_state;
  logic              eng_active;
  logic [CNT_W-1:0]  eng_cnt;

  assign line_bit = mdo_bit & mdo_en;

  mdio_edge_detect u_edge (
    .clk     (clk),
    .rst     (rst),
    .level_i (mdc_bit),
    .rise_o  (edge_rise)
  );

  mdio_regbank #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W),
    .ID0_IDX(ID0_IDX), .ID0_VAL(ID0_VAL),
    .ID1_IDX(ID1_IDX), .ID1_VAL(ID1_VAL)
  ) u_bank (
    .clk       (clk),
    .rst       (rst),
    .rd_addr_i (bank_addr),
    .rd_data_o (bank_data)
  );

  mdio_frame_engine #(
    .PRE_W (PRE_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_engine (
    .clk       (clk),
    .rst       (rst),
    .rise_i    (edge_rise),
    .bit_i     (line_bit),
    .rd_data_i (bank_data),
    .rd_addr_o (bank_addr),
    .din_o     (mdi_bit),
    .state_o   (eng_state),
    .active_o  (eng_active),
    .cnt_o     (eng_cnt)
  );
endmodule

// File: rtl/mdio_mgmt_slave_chk.sv
module mdio_mgmt_slave_chk
  import mdio_slave_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int PRE_W = 32,
  parameter int HDR_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             rise,
  input mslv_state_t      state,
  input logic             active,
  input logic [CNT_W-1:0] cnt,
  input logic             din
);
  // R9
  din_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rise |=> $stable(din));

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rise |=> ($stable(cnt) && $stable(state) && $stable(active)));

  // R6
  read_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(state == MS_READ) |-> ($past(rise) && $past(cnt) == CNT_W'(PRE_W - HDR_W)));

  // R10
  busy_needs_sync_chk: assert property (@(posedge clk) disable iff (rst)
    (state != MS_IDLE) |-> active);

  // R10
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(PRE_W));
endmodule

bind mdio_mgmt_slave mdio_mgmt_slave_chk #(
  .CNT_W(CNT_W), .PRE_W(PRE_W), .HDR_W(DATA_W)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .rise   (edge_rise),
  .state  (eng_state),
  .active (eng_active),
  .cnt    (eng_cnt),
  .din    (mdi_bit)
);

// File: tb/mdio_mgmt_slave_bench.sv
module mdio_mgmt_slave_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mdc = 1'b0, mdo = 1'b0, en = 1'b0;
  logic mdi;
  int   tests = 0, fails = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  mdio_mgmt_slave u_mdio_mgmt_slave (
    .clk(clk), .rst(rst), .mdc_bit(mdc), .mdo_bit(mdo), .mdo_en(en), .mdi_bit(mdi)
  );

  // Behavioural reference: unbounded counter, plain integers.
  logic        m_last, m_din;
  logic [31:0] m_hist;
  logic [15:0] m_out;
  int          m_cnt, m_mode;  // mode 0 idle, 1 read, 2 write

  function automatic logic [15:0] bank_val(input int a);
    if (a == 2) return 16'h0022;
    if (a == 3) return 16'h161A;
    return 16'h0000;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_last = 0; m_din = 0; m_hist = 0; m_out = 0; m_cnt = 0; m_mode = 0;
    end else begin
      if (mdc && !m_last) begin
        m_hist = {m_hist[30:0], mdo & en};
        if (m_hist == 32'hFFFF_FFFF) m_cnt = 32;
        if (m_cnt == 16) begin
          if (m_hist[15:14] == 2'b01 && m_hist[13:12] == 2'b01 && m_hist[1:0] == 2'b10)
            m_mode = 2;
          else if (m_hist[15:14] == 2'b01 && m_hist[13:12] == 2'b10 && !m_hist[0])
            m_mode = 1;
          else
            m_mode = 0;
          if (m_mode == 1) m_out = bank_val(int'(m_hist[6:2]));
        end
        if (m_cnt < 16 && m_mode == 1) begin
          m_din = m_out[15];
          m_out = m_out << 1;
        end
        if (m_cnt == 0) m_mode = 0;
        m_cnt = m_cnt - 1;
      end
      m_last = mdc;
    end
  end

  // R9 cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    if (!rst && !done) begin
      tests++;
      if (mdi !== m_din) begin
        fails++;
        $display("FAIL R9 cycle compare: mdi=%0b expected %0b at %0t", mdi, m_din, $time);
      end
    end
  end

  task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic one_edge(input logic b, input logic e, input int hold, output logic got);
    @(negedge clk); mdc = 1'b0; mdo = b; en = e;
    repeat (2) @(negedge clk);
    mdc = 1'b1;
    repeat (hold) @(negedge clk);
    got = mdi;
  endtask

  task automatic send_frame(input int pre, input logic pre_en, input logic [13:0] hdr,
                            input logic [1:0] ta, input logic ta_en,
                            input logic [15:0] wdata, input logic wen,
                            input int nresp, output logic [15:0] got);
    logic b;
    got = '0;
    for (int i = 0; i < pre; i++) one_edge(1'b1, pre_en, 2, b);
    for (int i = 13; i >= 0; i--) one_edge(hdr[i], 1'b1, 2, b);
    for (int i = 1; i >= 0; i--) one_edge(ta[i], ta_en, 2, b);
    for (int i = 15; i >= 16 - nresp; i--) begin
      one_edge(wdata[i], wen, 2, b);
      got = {got[14:0], b};
    end
  endtask

  function automatic logic [13:0] hdr(input logic [1:0] st, input logic [1:0] op,
                                      input logic [4:0] dev, input logic [4:0] rg);
    return {st, op, dev, rg};
  endfunction

  initial begin
    logic [15:0] v;
    logic b, hold_bit;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check16("R1 reset data bit", {15'd0, mdi}, 16'h0000);

    // R1 R5 plain reads of identifier and ordinary entries
    send_frame(32, 1, hdr(2'b01, 2'b10, 5'h01, 5'd2), 2'b00, 0, 16'h0, 0, 16, v);
    check16("R1 read reg2", v, 16'h0022);
    send_frame(32, 1, hdr(2'b01, 2'b10, 5'h1F, 5'd3), 2'b00, 0, 16'h0, 0, 16, v);
    check16("R5 read reg3 other device addr", v, 16'h161A);
    send_frame(32, 1, hdr(2'b01, 2'b10, 5'h00, 5'd0), 2'b00, 0, 16'h0, 0, 16, v);
    check16("R1 read reg0", v, 16'h0000);
    send_frame(32, 1, hdr(2'b01, 2'b10, 5'h00, 5'd17), 2'b00, 0, 16'h0, 0, 16, v);
    check16("R1 read reg17", v, 16'h0000);

    // R4 long preamble
    send_frame(40, 1, hdr(2'b01, 2'b10, 5'h03, 5'd3), 2'b00, 0, 16'h0, 0, 16, v);
    check16("R4 long preamble read", v, 16'h161A);

    // R8 writes are discarded
    send_frame(32, 1, hdr(2'b01, 2'b01, 5'h01, 5'd2), 2'b10, 1, 16'hABCD, 1, 16, v);
    check16("R8 data bit quiet during write", v, 16'h0000);
    send_frame(32, 1, hdr(2'b01, 2'b10, 5'h01, 5'd2), 2'b00, 0, 16'h0, 0, 16, v);
    check16("R8 reg2 after write", v, 16'h0022);
    send_frame(32, 1, hdr(2'b01, 2'b01, 5'h01, 5'd5), 2'b10, 1, 16'hFFFF, 1, 16, v);
    send_frame(32, 1, hdr(2'b01, 2'b10, 5'h01, 5'd5), 2'b00, 0, 16'h0, 0, 16, v);
    check16("R8 reg5 after write", v, 16'h0000);

    // R7 invalid start / opcode / turnaround
    send_frame(32, 1, hdr(2'b00, 2'b10, 5'h01, 5'd3), 2'b00, 0, 16'h0, 0, 16, v);
    check16("R7 bad start", v, 16'h0000);
    send_frame(32, 1, hdr(2'b01, 2'b11, 5'h01, 5'd3), 2'b00, 0, 16'h0, 0, 16, v);
    check16("R7 bad opcode 11", v, 16'h0000);
    send_frame(32, 1, hdr(2'b01, 2'b00, 5'h01, 5'd3), 2'b00, 0, 16'h0, 0, 16, v);
    check16("R7 bad opcode 00", v, 16'h0000);
    send_frame(32, 1, hdr(2'b01, 2'b10, 5'h01, 5'd3), 2'b01, 1, 16'h0, 0, 16, v);
    check16("R7 read turnaround 01", v, 16'h0000);

    // R6 read turnaround 10 is still a read
    send_frame(32, 1, hdr(2'b01, 2'b10, 5'h01, 5'd3), 2'b10, 1, 16'h0, 0, 16, v);
    check16("R6 read turnaround 10", v, 16'h161A);

    // R4 thirty-one ones do not sync
    send_frame(31, 1, hdr(2'b01, 2'b10, 5'h01, 5'd3), 2'b00, 0, 16'h0, 0, 16, v);
    check16("R4 short preamble", v, 16'h0000);

    // R3 preamble with enable low
    send_frame(32, 0, hdr(2'b01, 2'b10, 5'h01, 5'd3), 2'b00, 0, 16'h0, 0, 16, v);
    check16("R3 enable low preamble", v, 16'h0000);

    // R10 frame after the end without new preamble
    send_frame(32, 1, hdr(2'b01, 2'b10, 5'h01, 5'd2), 2'b00, 0, 16'h0, 0, 16, v);
    check16("R10 sync read", v, 16'h0022);
    send_frame(0, 1, hdr(2'b01, 2'b10, 5'h01, 5'd3), 2'b00, 0, 16'h0, 0, 16, v);
    check16("R10 no preamble read", v, 16'h0000);

    // R9 R2 host wiggle in the middle of an answer
    send_frame(32, 1, hdr(2'b01, 2'b10, 5'h01, 5'd2), 2'b00, 0, 16'h0, 0, 11, v);
    check16("R9 first eleven bits", {5'd0, v[10:0]}, {5'd0, 11'(16'h0022 >> 5)});
    hold_bit = mdi;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      mdo = i[0]; en = i[1];
      if (i == 6) mdc = 1'b0;
    end
    check16("R9 held bit", {15'd0, mdi}, {15'd0, hold_bit});
    check16("R9 held bit is bit5", {15'd0, mdi}, 16'h0001);
    v = '0;
    for (int i = 0; i < 5; i++) begin
      one_edge(1'b0, 1'b0, (i == 2) ? 9 : 2, b);
      v = {v[14:0], b};
    end
    check16("R2 remaining five bits", v, 16'h0002);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule